// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block is the master-side shift engine of an SPI controller. It takes bytes from a transmit queue that shows its head word without a read delay, and shifts each byte out on `mosi`. It captures the byte returned on `miso` and hands it to a receive queue with a one-cycle push strobe. The queues and the register file sit outside the block. The engine sees only two 32-bit control words, which it reads live: a configuration word and a delay word.

The configuration word chooses the serial clock polarity, the sampling phase and the rate. The serial clock period is 2^(p+1) system clocks for prescaler value p. The same word selects the slave, either as a raw 4-bit active-low pattern or decoded to one of sixteen lines. It can force the selected slave active, and it can hold transmission until a start pulse arrives.

The delay word sets four idle gaps, each counted in system clock cycles:
- the setup time from select assertion to the first clock edge,
- the hold time from the last edge of a burst to select release,
- the pause between back-to-back words while select stays asserted,
- the time select is released between words.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset `ss_n` is all ones, `sclk` equals the polarity bit (config bit 1), and `tx_pop` and `rx_push` are low.
- R2: While config bit 0 (master enable) is 0 no word is taken: `tx_pop` stays low and `ss_n` stays all ones.
- R3: `sclk` rests at config bit 1 when idle; during a word its period is 2^(p+1) clocks, where p is config bits 5:3.
- R4: Words are 8 bits, MSB first on `mosi`. With config bit 2 (phase) at 0, `miso` is sampled on leading edges and `mosi` changes on trailing edges; with phase 1 this is reversed. Each word gives exactly one `rx_push` pulse, with the received byte on `rx_data`.
- R5: With config bit 9 at 0, the active `ss_n[3:0]` equals config bits 13:10, `ss_n[15:4]` stay high, and value 15 selects nothing.
- R6: With config bit 9 at 1, an active select value v below 15 drives only `ss_n[v]` low; v = 15 selects nothing.
- R7: Config bit 14 holds the select active whether or not a transfer runs, including after a burst ends.
- R8: With config bit 15 at 1, queued data waits for a one-cycle pulse on config bit 16. A pulse given while idle with an empty queue is remembered until data arrives.
- R9: With config bit 15 at 0, a transfer starts as soon as the queue is non-empty.
- R10: Delay bits 7:0 lengthen the time from select assertion to the first `sclk` edge by exactly their value.
- R11: Delay bits 15:8 lengthen the time from the last `sclk` edge of a burst to select release by exactly their value. A burst ends when the queue is empty at a word boundary.
- R12: With delay bits 31:24 at 0, select stays asserted between consecutive words, and delay bits 23:16 lengthen the pause between them by exactly their value.
- R13: With delay bits 31:24 at n > 0, select is released for exactly n clocks between consecutive words.
- R14: `tx_pop` pulses only when the queue is non-empty, once per word, and the head byte is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word |
| dly_word | input | 32 | Delay word, four 8-bit gap fields |
| tx_empty | input | 1 | Transmit queue empty |
| tx_data | input | 8 | Head byte of transmit queue |
| tx_pop | output | 1 | Take head byte from transmit queue |
| rx_push | output | 1 | Received byte valid strobe |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 16 | Active-low slave select lines |

## Verification
The bench returns the inverted `mosi` on `miso` and rebuilds the sent byte from its own sampling of `sclk`. This exposes a reversed bit order, or sampling on the wrong phase: the received byte would be shifted by one bit or mirrored. Each delay field is measured as a difference between two runs. An off-by-one counter, or fields wired to the wrong gap, would show a difference other than the programmed value.

The bench also covers the following:
- Start gating, where a design that ignores the start pulse or drops a remembered one would transfer early or never.
- Select decoding for the value 15, which must select nothing.
- Forced select, which must survive the end of a burst.

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq #(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 3,
  parameter int SEL_W  = 4,
  parameter int DLY_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            cfg_word,
  input  logic [31:0]            dly_word,
  input  logic                   tx_empty,
  input  logic [DATA_W-1:0]      tx_data,
  output logic                   tx_pop,
  output logic                   rx_push,
  output logic [DATA_W-1:0]      rx_data,
  output logic                   sclk,
  output logic                   mosi,
  input  logic                   miso,
  output logic [(1<<SEL_W)-1:0]  ss_n
);

  localparam int DIV_W = (1 << PRE_W) - 1;
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_BTWN, S_GAP, S_TAIL} state_t;

  wire              en     = cfg_word[0];
  wire              cpol   = cfg_word[1];
  wire              cpha   = cfg_word[2];
  wire [PRE_W-1:0]  pre    = cfg_word[3 +: PRE_W];
  wire              dec    = cfg_word[9];
  wire [SEL_W-1:0]  sel    = cfg_word[10 +: SEL_W];
  wire              frc    = cfg_word[14];
  wire              man    = cfg_word[15];
  wire              mstart = cfg_word[16];
  wire              unused_cfg = ^{cfg_word[31:17], cfg_word[8:6]};

  wire [DLY_W-1:0] d_init  = dly_word[0       +: DLY_W];
  wire [DLY_W-1:0] d_after = dly_word[DLY_W   +: DLY_W];
  wire [DLY_W-1:0] d_btwn  = dly_word[2*DLY_W +: DLY_W];
  wire [DLY_W-1:0] d_nss   = dly_word[3*DLY_W +: DLY_W];

  state_t            st;
  logic [DLY_W-1:0]  cnt;
  logic [DIV_W-1:0]  div;
  logic [EW-1:0]     edg;
  logic              lvl, ss_act, start_pend;
  logic [DATA_W-1:0] sr, rx_sh;

  wire [DIV_W-1:0] half_m1 = DIV_W'((1 << pre) - 1);
  wire tick     = (st == S_SHIFT) && (div == half_m1);
  wire samp     = cpha ? edg[0] : ~edg[0];
  wire shft     = cpha ? (~edg[0] && edg != '0) : edg[0];
  wire last_edg = (edg == EW'(EDGES - 1));
  wire more     = en && !tx_empty;
  wire ss_on    = ss_act || frc;

  assign tx_pop = more && (((st == S_IDLE) && (!man || start_pend)) ||
                           (((st == S_BTWN) || (st == S_GAP)) && cnt == '0));
  assign sclk   = cpol ^ lvl;
  assign mosi   = sr[DATA_W-1];

  always_comb begin
    ss_n = '1;
    if (ss_on) begin
      if (dec) begin
        if (sel != '1) ss_n[sel] = 1'b0;
      end else begin
        ss_n[SEL_W-1:0] = sel;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      div        <= '0;
      edg        <= '0;
      lvl        <= 1'b0;
      sr         <= '0;
      rx_sh      <= '0;
      rx_data    <= '0;
      rx_push    <= 1'b0;
      ss_act     <= 1'b0;
      start_pend <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      if (!man || (tx_pop && st == S_IDLE)) start_pend <= 1'b0;
      else if (st == S_IDLE && mstart)      start_pend <= 1'b1;
      if (tx_pop) begin
        sr  <= tx_data;
        div <= '0;
        edg <= '0;
        lvl <= 1'b0;
      end
      case (st)
        S_IDLE: if (tx_pop) begin
          ss_act <= 1'b1;
          cnt    <= d_init;
          st     <= S_LEAD;
        end
        S_LEAD: if (cnt == '0) st <= S_SHIFT;
                else cnt <= cnt - 1'b1;
        S_SHIFT: if (!tick) div <= div + 1'b1;
        else begin
          div <= '0;
          lvl <= ~lvl;
          edg <= edg + 1'b1;
          if (samp) rx_sh <= {rx_sh[DATA_W-2:0], miso};
          if (shft) sr <= {sr[DATA_W-2:0], 1'b0};
          if (last_edg) begin
            rx_push <= 1'b1;
            rx_data <= cpha ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
            if (!more) begin
              st  <= S_TAIL;
              cnt <= d_after;
            end else if (d_nss == '0) begin
              st  <= S_BTWN;
              cnt <= d_btwn;
            end else begin
              st     <= S_GAP;
              cnt    <= d_nss - 1'b1;
              ss_act <= 1'b0;
            end
          end
        end
        S_BTWN: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (tx_pop) st <= S_SHIFT;
        else begin
          st  <= S_TAIL;
          cnt <= d_after;
        end
        S_GAP: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (tx_pop) begin
          ss_act <= 1'b1;
          cnt    <= d_init;
          st     <= S_LEAD;
        end else st <= S_IDLE;
        S_TAIL: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          ss_act <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R14
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_pop); // R2
  AST_MANUAL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (man && !start_pend && st == S_IDLE) |-> !tx_pop); // R8
  AST_SCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sclk) && $stable(cpol)) |-> $past(ss_act)); // R3
  AST_PUSH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !rx_push); // R4
  AST_DECODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> ($countones(~ss_n) <= 1)); // R6

endmodule

// File: tb/spi_xfer_seq_tb.sv
module spi_xfer_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg_w = 32'h0002_0000;
  logic [31:0] dly_w = 32'h0;
  logic tx_empty, tx_pop, rx_push, sclk, mosi, miso;
  logic [7:0] tx_data, rx_data;
  logic [15:0] ss_n;

  always #5 clk = ~clk;

  spi_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_w), .dly_word(dly_w),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_data(rx_data),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  assign miso = ~mosi;

  logic [7:0] q [0:15];
  int wr = 0, rd = 0;
  assign tx_empty = (wr == rd);
  assign tx_data  = q[rd % 16];
  always @(posedge clk) if (tx_pop) rd <= rd + 1;

  int checks = 0, failures = 0, cyc = 0;
  int t_fall = 0, t_rise = 0, t_first = 0, last_lead = 0, prev_lead = 0;
  int last_edge = 0, gap = 0, n_rise = 0, n_rx = 0;
  bit first_pend = 0;
  logic [15:0] ss_prev = 16'hFFFF, ss_act_val = 16'hFFFF;
  logic [7:0] mosi_cap = 8'h0;
  logic [7:0] rxq [0:63];
  logic [7:0] capq [0:63];

  always @(posedge clk) cyc = cyc + 1;

  always @(ss_n) begin
    if (ss_prev == 16'hFFFF && ss_n != 16'hFFFF) begin
      t_fall = cyc; gap = cyc - t_rise; first_pend = 1; ss_act_val = ss_n;
    end else if (ss_prev != 16'hFFFF && ss_n == 16'hFFFF) begin
      t_rise = cyc; n_rise++;
    end
    ss_prev = ss_n;
  end

  always @(sclk) begin
    if (ss_n != 16'hFFFF) begin
      last_edge = cyc;
      if (sclk != cfg_w[1]) begin
        prev_lead = last_lead; last_lead = cyc;
        if (first_pend) begin t_first = cyc; first_pend = 0; end
      end
      if ((sclk != cfg_w[1]) != cfg_w[2]) mosi_cap = {mosi_cap[6:0], mosi};
    end
  end

  always @(negedge clk) if (rx_push) begin
    rxq[n_rx % 64] = rx_data; capq[n_rx % 64] = mosi_cap; n_rx++;
  end

  // {cpol, cpha, prescaler, byte}
  localparam logic [12:0] VEC [0:5] = '{
    {1'b0, 1'b0, 3'd0, 8'hA5}, {1'b0, 1'b1, 3'd1, 8'h3C},
    {1'b1, 1'b0, 3'd2, 8'h81}, {1'b1, 1'b1, 3'd0, 8'h7E},
    {1'b0, 1'b0, 3'd3, 8'hC3}, {1'b1, 1'b1, 3'd1, 8'h01}};

  function automatic logic [31:0] mkcfg(bit en, bit cpol, bit cpha, logic [2:0] pre,
                                        bit dec, logic [3:0] sel, bit frc, bit man);
    logic [31:0] c;
    c = 32'h0002_0000;
    c[0] = en; c[1] = cpol; c[2] = cpha; c[5:3] = pre;
    c[9] = dec; c[13:10] = sel; c[14] = frc; c[15] = man;
    return c;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk);
    q[wr % 16] = b;
    wr++;
  endtask

  task automatic wait_rx(int target);
    for (int k = 0; k < 4000 && n_rx < target; k++) @(negedge clk);
    chk(n_rx >= target, "R4 word completion", n_rx, target);
  endtask

  int base, a0, a1, c0, c1, l0, l1, r0;

  initial begin
    repeat (3) @(negedge clk);
    chk(ss_n == 16'hFFFF && sclk == 1'b0 && !tx_pop && !rx_push, "R1 reset state",
        {ss_n, 7'b0, sclk, 6'b0, tx_pop, rx_push}, 32'hFFFF_0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: master enable low
    cfg_w = mkcfg(0, 0, 0, 0, 0, 0, 0, 0);
    push(8'h55);
    repeat (60) @(negedge clk);
    chk(rd == 0 && ss_n == 16'hFFFF && n_rx == 0, "R2 disabled idle", rd, 0);
    cfg_w = mkcfg(1, 0, 0, 0, 0, 0, 0, 0);
    wait_rx(1);
    chk(rxq[0] == 8'hAA, "R2 R9 start after enable", rxq[0], 8'hAA);
    repeat (20) @(negedge clk);

    // vector table: R3 R4 R9
    for (int i = 0; i < 6; i++) begin
      cfg_w = mkcfg(1, VEC[i][12], VEC[i][11], VEC[i][10:8], 0, 0, 0, 0);
      repeat (4) @(negedge clk);
      chk(sclk == VEC[i][12], "R3 idle level", sclk, VEC[i][12]);
      base = n_rx;
      push(VEC[i][7:0]);
      wait_rx(base + 1);
      chk(rxq[base] == ~VEC[i][7:0], "R4 R9 received byte", rxq[base], ~VEC[i][7:0]);
      chk(capq[base] == VEC[i][7:0], "R4 MSB first on mosi", capq[base], VEC[i][7:0]);
      chk(last_lead - prev_lead == (2 << VEC[i][10:8]), "R3 sclk period",
          last_lead - prev_lead, 2 << VEC[i][10:8]);
      repeat (10) @(negedge clk);
    end

    // R10 R11: setup and hold delays
    cfg_w = mkcfg(1, 0, 0, 0, 0, 0, 0, 0);
    dly_w = 32'h0;
    base = n_rx; push(8'h12); wait_rx(base + 1); repeat (20) @(negedge clk);
    a0 = t_first - t_fall; c0 = t_rise - last_edge;
    dly_w = 32'h0000_0705;
    base = n_rx; push(8'h34); wait_rx(base + 1); repeat (30) @(negedge clk);
    a1 = t_first - t_fall; c1 = t_rise - last_edge;
    chk(a1 - a0 == 5, "R10 setup delay", a1 - a0, 5);
    chk(c1 - c0 == 7, "R11 hold delay", c1 - c0, 7);

    // R12: pause between words, select held
    dly_w = 32'h0;
    r0 = n_rise; base = n_rx;
    push(8'h11); push(8'h22); wait_rx(base + 2); repeat (20) @(negedge clk);
    l0 = t_rise - t_fall;
    chk(n_rise - r0 == 1, "R12 select held across words", n_rise - r0, 1);
    chk(rxq[base + 1] == 8'hDD, "R12 second word", rxq[base + 1], 8'hDD);
    dly_w = 32'h0006_0000;
    r0 = n_rise; base = n_rx;
    push(8'h33); push(8'h44); wait_rx(base + 2); repeat (20) @(negedge clk);
    l1 = t_rise - t_fall;
    chk(l1 - l0 == 6, "R12 pause delay", l1 - l0, 6);
    chk(n_rise - r0 == 1, "R12 single release", n_rise - r0, 1);
    chk(rd == wr, "R14 one pop per word", rd, wr);

    // R13: select released between words
    dly_w = 32'h0400_0000;
    r0 = n_rise; base = n_rx;
    push(8'h5A); push(8'hC0); wait_rx(base + 2); repeat (20) @(negedge clk);
    chk(gap == 4, "R13 release width", gap, 4);
    chk(n_rise - r0 == 2, "R13 release count", n_rise - r0, 2);
    chk(rxq[base + 1] == 8'h3F, "R13 R14 second word", rxq[base + 1], 8'h3F);
    dly_w = 32'h0;

    // R8: manual start
    cfg_w = mkcfg(1, 0, 0, 0, 0, 0, 0, 1);
    base = n_rx; push(8'h96);
    repeat (60) @(negedge clk);
    chk(n_rx == base && rd != wr && ss_n == 16'hFFFF, "R8 waits for pulse", n_rx - base, 0);
    cfg_w[16] = 1'b1; @(negedge clk); cfg_w[16] = 1'b0;
    wait_rx(base + 1);
    chk(rxq[base] == 8'h69, "R8 runs after pulse", rxq[base], 8'h69);
    repeat (20) @(negedge clk);
    cfg_w[16] = 1'b1; @(negedge clk); cfg_w[16] = 1'b0;
    repeat (10) @(negedge clk);
    base = n_rx; push(8'hF0); wait_rx(base + 1);
    chk(rxq[base] == 8'h0F, "R8 remembered pulse", rxq[base], 8'h0F);
    repeat (20) @(negedge clk);

    // R5 R6 R7: select shaping
    cfg_w = mkcfg(1, 0, 0, 0, 0, 4'd9, 1, 0); repeat (2) @(negedge clk);
    chk(ss_n == 16'hFFF9, "R5 R7 direct forced", ss_n, 16'hFFF9);
    cfg_w = mkcfg(1, 0, 0, 0, 0, 4'd15, 1, 0); repeat (2) @(negedge clk);
    chk(ss_n == 16'hFFFF, "R5 value 15 none", ss_n, 16'hFFFF);
    cfg_w = mkcfg(1, 0, 0, 0, 1, 4'd5, 1, 0); repeat (2) @(negedge clk);
    chk(ss_n == 16'hFFDF, "R6 R7 decoded forced", ss_n, 16'hFFDF);
    cfg_w = mkcfg(1, 0, 0, 0, 1, 4'd15, 1, 0); repeat (2) @(negedge clk);
    chk(ss_n == 16'hFFFF, "R6 value 15 none", ss_n, 16'hFFFF);
    cfg_w = mkcfg(1, 0, 0, 0, 1, 4'd3, 0, 0); repeat (2) @(negedge clk);
    base = n_rx; push(8'h0F); wait_rx(base + 1);
    chk(ss_act_val == 16'hFFF7, "R6 decoded during transfer", ss_act_val, 16'hFFF7);
    repeat (20) @(negedge clk);
    cfg_w = mkcfg(1, 0, 0, 0, 0, 4'd0, 1, 0);
    base = n_rx; push(8'h77); wait_rx(base + 1);
    repeat (30) @(negedge clk);
    chk(ss_n == 16'hFFF0, "R7 forced after burst", ss_n, 16'hFFF0);
    chk(rxq[base] == 8'h88, "R7 data under force", rxq[base], 8'h88);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule